// File: doc/BRIEF.md
# Prescaled Modulus Timer

This block is a 16-bit up-counter driven by the bus clock through a power-of-two prescaler. A 3-bit select picks the number of bus cycles per count. The prescaler is a 7-stage binary counter. A new select value is adopted only when every prescaler stage reads zero, so the tick rate never changes partway through a prescale period.

In free-running mode the counter wraps from its top value to zero. Each such wrap sets a sticky overflow flag, and an enable bit routes that flag to an interrupt request. In modulus mode a match against the compare register restarts the counter. When the counter reaches the compare value it holds there for one bus cycle, then returns to zero together with the prescaler. One period is therefore the compare value times the division factor, plus one bus cycle. A restart that happens at the top value is not counted as an overflow.

A one-cycle compare event pulse marks each increment that lands on the compare value. A low timer enable freezes the counter and the prescaler. A synchronous active-high reset clears everything.

Top module: `prescaled_modtimer`

## Requirements
- R1: Select code s (3 bits, 0..7) makes the counter advance once every 2^s bus cycles. Code 0 gives one count per cycle and code 7 gives one count per 128 cycles. From the zero state, the first increment lands on the 2^s-th enabled clock edge.
- R2: With modulus mode off, the counter adds one on every prescaler tick and wraps from 0xFFFF to 0x0000.
- R3: With modulus mode on and a nonzero compare value C, the counter reaches C, keeps it for exactly one bus cycle, and on the next edge returns to 0 with the prescaler cleared. The repeat period is C·2^s + 1 bus cycles.
- R4: With modulus mode on and C = 0x0000, the counter stays at 0x0000.
- R5: A free-running wrap from 0xFFFF to 0x0000 sets the overflow flag on the same edge. The flag then stays set until the cycle after a clear strobe. A clear strobe in the same cycle as a wrap leaves the flag set.
- R6: With modulus mode on and C = 0xFFFF, the restart from 0xFFFF to 0x0000 leaves the overflow flag clear.
- R7: The interrupt request is high exactly when the overflow flag is set and the interrupt enable input is 1. The request responds combinationally to the enable.
- R8: A changed select code takes effect only once all 7 prescaler stages are zero. This happens every 128 enabled cycles in free-running mode, or at a modulus restart. Until then the old division stays in use.
- R9: The compare event output is high for the single cycle that follows an increment which made the counter equal to C. It is low otherwise.
- R10: Reset clears the counter, the prescaler and the flag, and the outputs read zero. While the timer enable is low, the counter and the prescaler phase hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_en | input | 1 | Counter and prescaler run when 1 |
| ovf_ie | input | 1 | Routes the overflow flag to the interrupt request |
| cnt_rst_en | input | 1 | Modulus mode: compare match restarts the counter |
| presc_sel | input | 3 | Division code, factor 2^code |
| cmp_val | input | 16 | Compare value |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Counter value |
| cmp_evt | output | 1 | One-cycle compare event |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The counter is run in free-running mode at division 1, 4 and 128, which separates a correct select-to-factor mapping from an off-by-one in the tick mask. A select change made mid-period, followed by counts read before and after the 128-cycle prescaler rollover, shows whether the switch was deferred. Modulus runs use compare values 3 (division 1), 2 (division 2) and 0. They measure the one-cycle hold at the compare value and the period including the extra bus cycle. Two full 65536-step runs contrast the free-running wrap, which raises the flag even when a clear arrives with it, against the compare restart at 0xFFFF, which must not. A freeze in the middle of a prescale period shows that the prescaler phase is held, not just the count.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
    localparam int CNT_W = 16;
    localparam int SEL_W = 3;
    localparam int PSC_W = (1 << SEL_W) - 1;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [PSC_W-1:0] psc_t;

    typedef struct packed {
        logic ovf_ie;
        logic mod_en;
        sel_t psc_sel;
    } ctrl_t;

    typedef struct packed {
        logic restart;
        logic wrap;
        logic tick;
    } cnt_ev_t;

    function automatic psc_t psc_mask(input sel_t s);
        logic [PSC_W:0] one_hot;
        one_hot = (PSC_W+1)'(1) << s;
        return psc_t'(one_hot - 1'b1);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  sel_t sel_req,
    input  logic restart,
    output logic tick
);
    psc_t pcnt;
    sel_t held_sel;
    sel_t eff_sel;
    psc_t mask;

    // adopt a new select only when all stages are zero
    always_comb begin
        eff_sel = (pcnt == '0) ? sel_req : held_sel;
        mask    = psc_mask(eff_sel);
        tick    = en && ((pcnt & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt     <= '0;
            held_sel <= '0;
        end else if (en) begin
            held_sel <= eff_sel;
            pcnt     <= restart ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic         mod_en,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] count,
    output logic         restart,
    output logic         wrap,
    output logic         hit
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt     = count + 1'b1;
        restart = en && mod_en && (count == cmp);
        wrap    = en && tick && !restart && (count == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            hit   <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (restart) begin
                count <= '0;
            end else if (en && tick) begin
                count <= nxt;
                hit   <= (nxt == cmp);
            end
        end
    end
endmodule

// File: rtl/tmr_ovf_flag.sv
`timescale 1ns/1ps
module tmr_ovf_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie,
    output logic flag,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end

    assign req = flag && ie;
endmodule

// File: rtl/prescaled_modtimer.sv
`timescale 1ns/1ps
module prescaled_modtimer
    import timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_en,
    input  logic             ovf_ie,
    input  logic             cnt_rst_en,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic [W-1:0]     cmp_val,
    input  logic             flag_clr,
    output logic [W-1:0]     count,
    output logic             cmp_evt,
    output logic             ovf_flag,
    output logic             irq
);
    ctrl_t   ctrl;
    cnt_ev_t ev;

    assign ctrl = '{ovf_ie: ovf_ie, mod_en: cnt_rst_en, psc_sel: presc_sel};

    tmr_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .en      (tmr_en),
        .sel_req (ctrl.psc_sel),
        .restart (ev.restart),
        .tick    (ev.tick)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (tmr_en),
        .tick    (ev.tick),
        .mod_en  (ctrl.mod_en),
        .cmp     (cmp_val),
        .count   (count),
        .restart (ev.restart),
        .wrap    (ev.wrap),
        .hit     (cmp_evt)
    );

    tmr_ovf_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (ev.wrap),
        .clr_i (flag_clr),
        .ie    (ctrl.ovf_ie),
        .flag  (ovf_flag),
        .req   (irq)
    );
endmodule

// File: rtl/modtimer_chk.sv
`timescale 1ns/1ps
module modtimer_chk
    import timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tmr_en,
    input logic             ovf_ie,
    input logic             cnt_rst_en,
    input logic [CNT_W-1:0] cmp_val,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             cmp_evt,
    input logic             ovf_flag,
    input logic             irq
);
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && !cnt_rst_en) |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R2
    AST_MOD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && cnt_rst_en && count == cmp_val) |=> (count == '0)); // R3
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_rst_en && cmp_val == '0 && count == '0) |=> (count == '0)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && cnt_rst_en && cmp_val == '1 && count == '1 && !ovf_flag) |=> !ovf_flag); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !ovf_ie |-> !irq); // R7
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |=> (!cmp_evt || cmp_val != $past(cmp_val))); // R9
    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !tmr_en |=> $stable(count)); // R10
endmodule

bind prescaled_modtimer modtimer_chk u_chk (.*);

// File: tb/tb_prescaled_modtimer.sv
`timescale 1ns/1ps
module tb_prescaled_modtimer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_en = 1'b0;
    logic        ovf_ie = 1'b0;
    logic        cnt_rst_en = 1'b0;
    logic [2:0]  presc_sel = 3'd0;
    logic [15:0] cmp_val = 16'h0;
    logic        flag_clr = 1'b0;
    logic [15:0] count;
    logic        cmp_evt, ovf_flag, irq;

    always #5 clk = ~clk;

    prescaled_modtimer dut (
        .clk(clk), .rst(rst), .tmr_en(tmr_en), .ovf_ie(ovf_ie),
        .cnt_rst_en(cnt_rst_en), .presc_sel(presc_sel), .cmp_val(cmp_val),
        .flag_clr(flag_clr), .count(count), .cmp_evt(cmp_evt),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct {
        int          when;
        logic [15:0] cnt;
        logic        flg;
        logic        rq;
        logic        evt;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // driver side: schedule an expectation n edges ahead
    task automatic expect_in(input int n, input logic [15:0] c, input logic f,
                             input logic i, input logic e, input string req);
        exp_t it;
        it.when = cyc + n; it.cnt = c; it.flg = f; it.rq = i; it.evt = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic advance(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; tmr_en = 1'b0; flag_clr = 1'b0;
        advance(1);
        rst = 1'b0;
    endtask

    task automatic setup(input logic mod, input logic [2:0] s,
                         input logic [15:0] c, input logic ie);
        cnt_rst_en = mod; presc_sel = s; cmp_val = c; ovf_ie = ie; tmr_en = 1'b1;
    endtask

    // monitor: compare after each edge
    always begin
        @(posedge clk);
        #2;
        cyc++;
        while (q.size() > 0 && q[0].when <= cyc) begin
            exp_t it;
            it = q.pop_front();
            n_cmp++;
            if (it.when != cyc || count !== it.cnt || ovf_flag !== it.flg ||
                irq !== it.rq || cmp_evt !== it.evt) begin
                n_bad++;
                $display("FAIL %s @%0d: got cnt=%h flag=%b irq=%b evt=%b, exp cnt=%h flag=%b irq=%b evt=%b",
                         it.req, it.when, count, ovf_flag, irq, cmp_evt,
                         it.cnt, it.flg, it.rq, it.evt);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        advance(2);
        // R10 reset state
        expect_in(1, 16'h0, 0, 0, 0, "R10 reset");
        advance(1);
        rst = 1'b0;

        // R1 R2 R9 division 1, compare 5
        do_reset();
        setup(0, 3'd0, 16'h0005, 0);
        expect_in(3, 16'd3, 0, 0, 0, "R1 div1");
        expect_in(5, 16'd5, 0, 0, 1, "R9 evt");
        expect_in(6, 16'd6, 0, 0, 0, "R9 evt single");
        advance(6);

        // R1 division 4
        do_reset();
        setup(0, 3'd2, 16'h0100, 0);
        expect_in(3, 16'd0, 0, 0, 0, "R1 div4 pre");
        expect_in(4, 16'd1, 0, 0, 0, "R1 div4 first");
        expect_in(8, 16'd2, 0, 0, 0, "R1 div4 second");
        expect_in(11, 16'd2, 0, 0, 0, "R1 div4 hold");
        advance(11);

        // R1 division 128
        do_reset();
        setup(0, 3'd7, 16'h0100, 0);
        expect_in(127, 16'd0, 0, 0, 0, "R1 div128 pre");
        expect_in(128, 16'd1, 0, 0, 0, "R1 div128 first");
        advance(128);

        // R8 deferred select change
        do_reset();
        setup(0, 3'd2, 16'h0100, 0);
        advance(6);
        presc_sel = 3'd0;
        expect_in(14, 16'd5, 0, 0, 0, "R8 old factor kept");
        expect_in(122, 16'd32, 0, 0, 0, "R8 at stage zero");
        expect_in(124, 16'd34, 0, 0, 0, "R8 new factor");
        advance(124);

        // R3 modulus compare 3, division 1
        do_reset();
        setup(1, 3'd0, 16'h0003, 0);
        expect_in(3, 16'd3, 0, 0, 1, "R3 reach C");
        expect_in(4, 16'd0, 0, 0, 0, "R3 restart");
        expect_in(7, 16'd3, 0, 0, 1, "R3 period");
        expect_in(8, 16'd0, 0, 0, 0, "R3 restart 2");
        advance(8);

        // R3 modulus compare 2, division 2
        do_reset();
        setup(1, 3'd1, 16'h0002, 0);
        expect_in(4, 16'd2, 0, 0, 1, "R3 div2 reach");
        expect_in(5, 16'd0, 0, 0, 0, "R3 div2 restart");
        expect_in(7, 16'd1, 0, 0, 0, "R3 div2 prescaler cleared");
        expect_in(9, 16'd2, 0, 0, 1, "R3 div2 period");
        expect_in(10, 16'd0, 0, 0, 0, "R3 div2 restart 2");
        advance(10);

        // R4 compare zero
        do_reset();
        setup(1, 3'd0, 16'h0000, 0);
        expect_in(10, 16'd0, 0, 0, 0, "R4 zero hold");
        advance(10);

        // R10 freeze mid-period
        do_reset();
        setup(0, 3'd2, 16'h0100, 0);
        advance(6);
        tmr_en = 1'b0;
        expect_in(10, 16'd1, 0, 0, 0, "R10 frozen");
        advance(10);
        tmr_en = 1'b1;
        expect_in(1, 16'd1, 0, 0, 0, "R10 phase held");
        expect_in(2, 16'd2, 0, 0, 0, "R10 resume");
        advance(2);

        // R5 R7 free-running wrap
        do_reset();
        setup(0, 3'd0, 16'h1234, 1);
        expect_in(65535, 16'hFFFF, 0, 0, 0, "R5 top");
        advance(65535);
        flag_clr = 1'b1;
        expect_in(1, 16'h0000, 1, 1, 0, "R5 set wins over clear");
        advance(1);
        flag_clr = 1'b0;
        ovf_ie = 1'b0;
        expect_in(1, 16'h0001, 1, 0, 0, "R7 masked");
        advance(1);
        flag_clr = 1'b1;
        expect_in(1, 16'h0002, 0, 0, 0, "R5 cleared");
        advance(1);
        flag_clr = 1'b0;

        // R6 restart at top leaves flag clear
        do_reset();
        setup(1, 3'd0, 16'hFFFF, 1);
        expect_in(65535, 16'hFFFF, 0, 0, 1, "R6 top");
        expect_in(65536, 16'h0000, 0, 0, 0, "R6 no overflow");
        expect_in(65537, 16'h0001, 0, 0, 0, "R6 after");
        advance(65538);

        done = 1'b1;
        if (q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: got %0d pending, exp 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule